// File: doc/BRIEF.md
# Miss-Driven Row Promotion Controller

This block sits beside the controller of a slow, non-volatile memory tier. It decides which rows should be copied up into the fast DRAM tier. For every access to the slow tier it receives one event: the row number, whether the access is a write, and whether it hit the open row buffer. Only row-buffer misses count toward promotion. A row that keeps missing gains nothing from row-buffer locality, so it is the row that benefits most from living in DRAM. Writes weigh more than reads, so write-heavy rows reach DRAM sooner and the slow tier wears less.

A small fully associative table tracks the rows that missed most recently. When a tracked row's miss count reaches the current threshold, the block issues one promotion request for that row and frees its table entry. Software or a caller marks epoch boundaries with a one-cycle pulse. At each boundary the threshold moves one step. It goes down when the promotions made during the closing epoch are estimated to have paid for themselves, and up otherwise. The data mover that performs the copy, and all management of DRAM space, sit outside this block.

Top module: `mig_promote_ctrl`

## Requirements
- R1: After reset no request is pending (`mig_valid_o` = 0) and the threshold output equals THR_INIT (default 4).
- R2: An event with `acc_hit_i` = 1 has no effect on the table. It changes no count, allocates no entry and does not refresh recency, so later misses behave as if the hit never happened.
- R3: A read miss adds 1 to the row's miss count. A write miss adds 1 + WRITE_BONUS (default 3 in total) and also adds 1 to the row's write count. Both counts saturate, the miss count at 31 and the write count at 15 by default.
- R4: When a tracked row's miss count is at or above the threshold and no request is pending, a request carrying that row appears on the clock edge after the miss that crossed the threshold. The row's entry is freed on that same edge, so the row must miss again from zero to be requested again.
- R5: While `mig_valid_o` = 1 and `mig_ready_i` = 0, `mig_row_o` stays constant and no other request is issued. After the handshake edge `mig_valid_o` is 0 for at least one cycle.
- R6: If several rows qualify, the row with the largest write count is issued first. Ties go to the lowest table slot, and a new row always takes the lowest free slot.
- R7: A miss on an untracked row allocates a free slot. When every slot is in use, it replaces the row whose most recent miss is oldest, and that row's counts are lost.
- R8: On the edge where `epoch_end_i` = 1 the threshold is updated. Let S be the sum of the miss counts of the rows issued in the closing epoch and N the number of rows issued. If 3·S > 10·N, the threshold decreases by 1; otherwise it increases by 1. The result is clamped to the range 2..15, a request issued on the boundary edge itself counts toward the closing epoch, and the threshold changes on no other edge.
- R9: A miss to a row in the same cycle as that row's request is issued starts a fresh entry with that miss as its only count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Slow-tier access event present |
| acc_row_i | input | ROW_W | Row number of the access |
| acc_write_i | input | 1 | Access is a write |
| acc_hit_i | input | 1 | Access hit the open row buffer |
| epoch_end_i | input | 1 | One-cycle epoch boundary marker |
| mig_ready_i | input | 1 | Data mover accepts the request |
| mig_valid_o | output | 1 | Promotion request pending |
| mig_row_o | output | ROW_W | Row to promote |
| thr_o | output | CNT_W | Current promotion threshold |

## Verification
The hardest condition to reach from the ports is the collision between an issue and a new event. A row's request leaves the table on the same edge that a fresh miss to that row arrives. The stimulus reaches it by driving misses to one row back to back, so the miss after the crossing lands on the issue edge. A second hard case is a set of rows that all qualify while a request is stalled, which exposes the write-count priority and the slot tie-break once the request is released. Driving the threshold to both clamps needs many epochs. Each epoch that should lower the threshold parks a heavily missed row behind a stalled request, so its large count dominates the benefit estimate.

// File: rtl/mig_pkg.sv
package mig_pkg;

  // a + b, limited to lim
  function automatic int sat_add(int a, int b, int lim);
    return (a + b > lim) ? lim : a + b;
  endfunction

endpackage

// File: rtl/mig_track_table.sv
module mig_track_table #(
  parameter int ENTRIES     = 4,
  parameter int ROW_W       = 16,
  parameter int CNT_W       = 5,
  parameter int WR_W        = 4,
  parameter int WRITE_BONUS = 2,
  localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             acc_valid_i,
  input  logic [ROW_W-1:0]                 acc_row_i,
  input  logic                             acc_write_i,
  input  logic                             acc_hit_i,
  input  logic                             issue_en_i,
  input  logic [IDX_W-1:0]                 issue_idx_i,
  output logic [ENTRIES-1:0]               valid_o,
  output logic [ENTRIES-1:0][ROW_W-1:0]    tag_o,
  output logic [ENTRIES-1:0][CNT_W-1:0]    miss_o,
  output logic [ENTRIES-1:0][WR_W-1:0]     wr_o
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int WR_MAX  = (1 << WR_W) - 1;

  logic [ENTRIES-1:0]             valid_q, eff_valid, match, touch;
  logic [ENTRIES-1:0][ROW_W-1:0]  tag_q;
  logic [ENTRIES-1:0][CNT_W-1:0]  miss_q;
  logic [ENTRIES-1:0][WR_W-1:0]   wr_q;
  logic [ENTRIES-1:0][IDX_W-1:0]  age_q;
  logic                           upd, hit_any, free_any;
  logic [IDX_W-1:0]               hit_idx, free_idx, lru_idx, tgt_idx;
  logic [CNT_W-1:0]               miss_new;
  logic [WR_W-1:0]                wr_new;

  // the entry being issued this cycle counts as already free
  always_comb begin
    eff_valid = valid_q;
    if (issue_en_i) eff_valid[issue_idx_i] = 1'b0;
  end

  assign upd = acc_valid_i && !acc_hit_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = eff_valid[g] && (tag_q[g] == acc_row_i);
    assign touch[g] = upd && (tgt_idx == IDX_W'(g));
  end

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    lru_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!eff_valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (age_q[i] == IDX_W'(ENTRIES - 1)) lru_idx = IDX_W'(i);
    end
    tgt_idx  = hit_any ? hit_idx : (free_any ? free_idx : lru_idx);
    miss_new = CNT_W'(mig_pkg::sat_add(hit_any ? int'(miss_q[tgt_idx]) : 0,
                                       acc_write_i ? WRITE_BONUS + 1 : 1, CNT_MAX));
    wr_new   = WR_W'(mig_pkg::sat_add(hit_any ? int'(wr_q[tgt_idx]) : 0,
                                      acc_write_i ? 1 : 0, WR_MAX));
  end

  // ages stay a permutation of 0..ENTRIES-1; 0 is most recent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        miss_q[i] <= '0;
        wr_q[i]   <= '0;
        age_q[i]  <= IDX_W'(i);
      end
    end else begin
      valid_q <= eff_valid | touch;
      for (int i = 0; i < ENTRIES; i++) begin
        if (touch[i]) begin
          tag_q[i]  <= acc_row_i;
          miss_q[i] <= miss_new;
          wr_q[i]   <= wr_new;
          age_q[i]  <= '0;
        end else if (upd && (age_q[i] < age_q[tgt_idx])) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign miss_o  = miss_q;
  assign wr_o    = wr_q;

endmodule

// File: rtl/mig_pick.sv
module mig_pick #(
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 5,
  parameter int WR_W    = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][CNT_W-1:0] miss_i,
  input  logic [ENTRIES-1:0][WR_W-1:0]  wr_i,
  input  logic [CNT_W-1:0]              thr_i,
  output logic                          any_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [ENTRIES-1:0] cand;
  logic [WR_W-1:0]    best;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cand
    assign cand[g] = valid_i[g] && (miss_i[g] >= thr_i);
  end

  // strictly larger write count replaces; ties keep the lower slot
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (cand[i] && (!any_o || (wr_i[i] > best))) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = wr_i[i];
      end
    end
  end

endmodule

// File: rtl/mig_thr_tune.sv
module mig_thr_tune #(
  parameter int CNT_W    = 5,
  parameter int ACC_W    = 16,
  parameter int THR_MIN  = 2,
  parameter int THR_MAX  = 15,
  parameter int THR_INIT = 4,
  parameter int LAT_DIFF = 3,
  parameter int MIG_COST = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_en_i,
  input  logic [CNT_W-1:0] issue_miss_i,
  input  logic             epoch_end_i,
  output logic [CNT_W-1:0] thr_o
);
  localparam int PROD_W = 2 * ACC_W;

  logic [ACC_W-1:0]  sum_q, sum_d, cnt_q, cnt_d;
  logic [PROD_W-1:0] benefit, cost;
  logic [CNT_W-1:0]  thr_q, thr_d;

  always_comb begin
    sum_d   = sum_q + (issue_en_i ? ACC_W'(issue_miss_i) : '0);
    cnt_d   = cnt_q + ACC_W'(issue_en_i);
    benefit = PROD_W'(sum_d) * PROD_W'(LAT_DIFF);
    cost    = PROD_W'(cnt_d) * PROD_W'(MIG_COST);
    thr_d   = thr_q;
    if (epoch_end_i) begin
      if (benefit > cost)
        thr_d = (thr_q > CNT_W'(THR_MIN)) ? thr_q - 1'b1 : CNT_W'(THR_MIN);
      else
        thr_d = (thr_q < CNT_W'(THR_MAX)) ? thr_q + 1'b1 : CNT_W'(THR_MAX);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
      thr_q <= CNT_W'(THR_INIT);
    end else begin
      thr_q <= thr_d;
      sum_q <= epoch_end_i ? '0 : sum_d;
      cnt_q <= epoch_end_i ? '0 : cnt_d;
    end
  end

  assign thr_o = thr_q;

endmodule

// File: rtl/mig_promote_ctrl.sv
module mig_promote_ctrl #(
  parameter int ROW_W       = 16,
  parameter int ENTRIES     = 4,
  parameter int CNT_W       = 5,
  parameter int WR_W        = 4,
  parameter int WRITE_BONUS = 2,
  parameter int THR_MIN     = 2,
  parameter int THR_MAX     = 15,
  parameter int THR_INIT    = 4,
  parameter int LAT_DIFF    = 3,
  parameter int MIG_COST    = 10,
  parameter int ACC_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [ROW_W-1:0] acc_row_i,
  input  logic             acc_write_i,
  input  logic             acc_hit_i,
  input  logic             epoch_end_i,
  input  logic             mig_ready_i,
  output logic             mig_valid_o,
  output logic [ROW_W-1:0] mig_row_o,
  output logic [CNT_W-1:0] thr_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0][ROW_W-1:0] ent_tag;
  logic [ENTRIES-1:0][CNT_W-1:0] ent_miss;
  logic [ENTRIES-1:0][WR_W-1:0]  ent_wr;
  logic                          pick_any, issue_en;
  logic [IDX_W-1:0]              pick_idx;
  logic                          mig_valid_q;
  logic [ROW_W-1:0]              mig_row_q;
  logic [CNT_W-1:0]              thr;

  assign issue_en = pick_any && !mig_valid_q;

  mig_track_table #(
    .ENTRIES(ENTRIES), .ROW_W(ROW_W), .CNT_W(CNT_W), .WR_W(WR_W),
    .WRITE_BONUS(WRITE_BONUS)
  ) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .acc_valid_i(acc_valid_i), .acc_row_i(acc_row_i),
    .acc_write_i(acc_write_i), .acc_hit_i(acc_hit_i),
    .issue_en_i(issue_en), .issue_idx_i(pick_idx),
    .valid_o(ent_valid), .tag_o(ent_tag), .miss_o(ent_miss), .wr_o(ent_wr)
  );

  mig_pick #(
    .ENTRIES(ENTRIES), .CNT_W(CNT_W), .WR_W(WR_W)
  ) u_pick (
    .valid_i(ent_valid), .miss_i(ent_miss), .wr_i(ent_wr), .thr_i(thr),
    .any_o(pick_any), .idx_o(pick_idx)
  );

  mig_thr_tune #(
    .CNT_W(CNT_W), .ACC_W(ACC_W), .THR_MIN(THR_MIN), .THR_MAX(THR_MAX),
    .THR_INIT(THR_INIT), .LAT_DIFF(LAT_DIFF), .MIG_COST(MIG_COST)
  ) u_tune (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .issue_en_i(issue_en), .issue_miss_i(ent_miss[pick_idx]),
    .epoch_end_i(epoch_end_i), .thr_o(thr)
  );

  // one request in flight; a new one only after a free cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mig_valid_q <= 1'b0;
      mig_row_q   <= '0;
    end else if (issue_en) begin
      mig_valid_q <= 1'b1;
      mig_row_q   <= ent_tag[pick_idx];
    end else if (mig_valid_q && mig_ready_i) begin
      mig_valid_q <= 1'b0;
    end
  end

  assign mig_valid_o = mig_valid_q;
  assign mig_row_o   = mig_row_q;
  assign thr_o       = thr;

endmodule

// File: rtl/mig_promote_ctrl_chk.sv
module mig_promote_ctrl_chk #(
  parameter int ROW_W   = 16,
  parameter int CNT_W   = 5,
  parameter int THR_MIN = 2,
  parameter int THR_MAX = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             epoch_end_i,
  input logic             mig_ready_i,
  input logic             mig_valid_o,
  input logic [ROW_W-1:0] mig_row_o,
  input logic [CNT_W-1:0] thr_o
);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mig_valid_o && !mig_ready_i |=> mig_valid_o && $stable(mig_row_o));

  assert_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mig_valid_o && mig_ready_i |=> !mig_valid_o);

  assert_thr_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_o >= CNT_W'(THR_MIN)) && (thr_o <= CNT_W'(THR_MAX)));

  assert_thr_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epoch_end_i |=> $stable(thr_o));

  assert_thr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_end_i |=> (thr_o == $past(thr_o) + 1'b1) ||
                    (thr_o == $past(thr_o) - 1'b1) || $stable(thr_o));

endmodule

bind mig_promote_ctrl mig_promote_ctrl_chk #(
  .ROW_W(ROW_W), .CNT_W(CNT_W), .THR_MIN(THR_MIN), .THR_MAX(THR_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .epoch_end_i(epoch_end_i),
  .mig_ready_i(mig_ready_i), .mig_valid_o(mig_valid_o),
  .mig_row_o(mig_row_o), .thr_o(thr_o)
);

// File: tb/mig_promote_ctrl_tb.sv
module mig_promote_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ENT   = 4;
  localparam int CMAX  = 31;
  localparam int WMAX  = 15;
  localparam int BONUS = 2;
  localparam int TMIN  = 2;
  localparam int TMAX  = 15;
  localparam int TINIT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_row = '0;
  logic        acc_write = 1'b0;
  logic        acc_hit = 1'b0;
  logic        epoch_end = 1'b0;
  logic        mig_ready = 1'b0;
  logic        mig_valid;
  logic [15:0] mig_row;
  logic [4:0]  thr;

  int n_checks = 0;
  int n_fail = 0;
  bit run = 0;
  string cur = "R1";

  mig_promote_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_row_i(acc_row),
    .acc_write_i(acc_write), .acc_hit_i(acc_hit),
    .epoch_end_i(epoch_end), .mig_ready_i(mig_ready),
    .mig_valid_o(mig_valid), .mig_row_o(mig_row), .thr_o(thr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- reference model ----------------
  bit m_valid [ENT];
  int m_tag   [ENT];
  int m_miss  [ENT];
  int m_wr    [ENT];
  int lru_q[$];          // slot numbers, most recent first
  bit m_mv;
  int m_row, m_thr, m_sum, m_cnt;

  task automatic model_reset();
    for (int s = 0; s < ENT; s++) begin
      m_valid[s] = 0; m_tag[s] = 0; m_miss[s] = 0; m_wr[s] = 0;
    end
    lru_q = {};
    for (int s = 0; s < ENT; s++) lru_q.push_back(s);
    m_mv = 0; m_row = 0; m_thr = TINIT; m_sum = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    int pick = -1;
    int bw = -1;
    int slot = -1;
    bit found = 0;
    for (int s = 0; s < ENT; s++)
      if (m_valid[s] && m_miss[s] >= m_thr && m_wr[s] > bw) begin
        pick = s; bw = m_wr[s];
      end
    if (m_mv) begin
      if (mig_ready) m_mv = 0;
    end else if (pick >= 0) begin
      m_mv = 1; m_row = m_tag[pick]; m_valid[pick] = 0;
      m_sum += m_miss[pick]; m_cnt++;
    end
    if (acc_valid && !acc_hit) begin
      int inc = acc_write ? 1 + BONUS : 1;
      int w = acc_write ? 1 : 0;
      for (int s = 0; s < ENT; s++)
        if (!found && m_valid[s] && m_tag[s] == int'(acc_row)) begin
          slot = s; found = 1;
        end
      if (!found)
        for (int s = ENT - 1; s >= 0; s--) if (!m_valid[s]) slot = s;
      if (slot < 0) slot = lru_q[$];
      if (found) begin
        m_miss[slot] = (m_miss[slot] + inc > CMAX) ? CMAX : m_miss[slot] + inc;
        m_wr[slot]   = (m_wr[slot] + w > WMAX) ? WMAX : m_wr[slot] + w;
      end else begin
        m_miss[slot] = inc; m_wr[slot] = w;
      end
      m_valid[slot] = 1; m_tag[slot] = int'(acc_row);
      for (int k = 0; k < lru_q.size(); k++)
        if (lru_q[k] == slot) begin lru_q.delete(k); break; end
      lru_q.push_front(slot);
    end
    if (epoch_end) begin
      if (m_sum * 3 > m_cnt * 10) m_thr = (m_thr > TMIN) ? m_thr - 1 : TMIN;
      else                        m_thr = (m_thr < TMAX) ? m_thr + 1 : TMAX;
      m_sum = 0; m_cnt = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (run) begin
      check(cur, "model mig_valid", int'(mig_valid), int'(m_mv));
      check(cur, "model thr", int'(thr), m_thr);
      if (m_mv) check(cur, "model mig_row", int'(mig_row), m_row);
    end
  end

  // ---------------- stimulus helpers (called at negedge) ----------------
  task automatic acc(int row, bit wr, bit hit);
    acc_valid = 1'b1; acc_row = 16'(row); acc_write = wr; acc_hit = hit;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_hit = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ready();
    mig_ready = 1'b1;
    @(negedge clk);
    mig_ready = 1'b0;
  endtask

  task automatic pulse_epoch();
    epoch_end = 1'b1;
    @(negedge clk);
    epoch_end = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    run = 1;

    // R1 reset state
    cur = "R1";
    check("R1", "mig_valid", int'(mig_valid), 0);
    check("R1", "thr", int'(thr), 4);

    // R2 hits ignored, R4 crossing
    cur = "R2";
    repeat (3) acc(16'h10, 0, 0);
    repeat (5) acc(16'h10, 0, 1);
    idle(3);
    check("R2", "no request after hits", int'(mig_valid), 0);
    cur = "R4";
    acc(16'h10, 0, 0);
    idle(1);
    check("R4", "request raised", int'(mig_valid), 1);
    check("R4", "request row", int'(mig_row), 16'h10);
    pulse_ready();
    check("R5", "gap after handshake", int'(mig_valid), 0);

    // R3 write weighting
    cur = "R3";
    acc(16'h20, 1, 0);
    idle(3);
    check("R3", "write miss below thr", int'(mig_valid), 0);
    acc(16'h20, 0, 0);
    idle(1);
    check("R3", "write row requested", int'(mig_valid), 1);
    check("R3", "write row id", int'(mig_row), 16'h20);
    pulse_ready();

    // R5 stall and R6 priority
    cur = "R6";
    repeat (4) acc(16'h30, 0, 0);
    repeat (4) acc(16'h31, 0, 0);
    acc(16'h32, 1, 0);
    acc(16'h32, 0, 0);
    repeat (4) acc(16'h33, 0, 0);
    idle(5);
    check("R5", "stalled row held", int'(mig_row), 16'h30);
    check("R5", "stalled valid held", int'(mig_valid), 1);
    pulse_ready();
    check("R5", "gap", int'(mig_valid), 0);
    idle(1);
    check("R6", "write-heavy first", int'(mig_row), 16'h32);
    pulse_ready();
    idle(1);
    check("R6", "tie lower slot", int'(mig_row), 16'h31);
    pulse_ready();
    idle(1);
    check("R6", "last candidate", int'(mig_row), 16'h33);
    pulse_ready();

    // R7 replacement of least recently missed row
    cur = "R7";
    for (int r = 0; r < 4; r++) repeat (2) acc(16'h40 + r, 0, 0);
    acc(16'h40, 0, 0);
    acc(16'h44, 0, 0);
    repeat (2) acc(16'h41, 0, 0);
    idle(3);
    check("R7", "evicted row restarted", int'(mig_valid), 0);
    acc(16'h40, 0, 0);
    idle(1);
    check("R7", "kept row promoted", int'(mig_row), 16'h40);
    check("R7", "kept row valid", int'(mig_valid), 1);
    pulse_ready();
    idle(2);

    // R9 miss on the issue edge
    cur = "R9";
    repeat (5) acc(16'h50, 0, 0);
    idle(1);
    check("R9", "first request", int'(mig_row), 16'h50);
    pulse_ready();
    repeat (2) acc(16'h50, 0, 0);
    idle(3);
    check("R9", "fresh entry count", int'(mig_valid), 0);
    acc(16'h50, 0, 0);
    idle(1);
    check("R9", "second request", int'(mig_valid), 1);
    pulse_ready();
    idle(2);

    // R8 epoch tuning
    cur = "R8";
    pulse_epoch();
    idle(2);
    t0 = int'(thr);
    pulse_epoch();
    idle(2);
    check("R8", "idle epoch raises", int'(thr), (t0 < TMAX) ? t0 + 1 : TMAX);
    repeat (16) begin
      pulse_epoch();
      idle(1);
    end
    idle(1);
    check("R8", "clamp at max", int'(thr), 15);
    for (int i = 0; i < 15; i++) begin
      int t;
      t = int'(thr);
      repeat (t) acc(16'h60 + i, 0, 0);
      idle(2);
      repeat (40) acc(16'h80 + i, 0, 0);
      mig_ready = 1'b1;
      idle(12);
      mig_ready = 1'b0;
      pulse_epoch();
      idle(2);
      if (i == 0) check("R8", "paying epoch lowers", int'(thr), 14);
    end
    check("R8", "clamp at min", int'(thr), 2);

    idle(2);
    finish_run();
  end

endmodule